// File: doc/BRIEF.md
# Double-Buffered Window Configuration Bank

This block keeps the configuration of a set of display windows in two copies. Software edits a staging copy through a plain register write port. The display pipeline only ever sees a live copy, which is driven onto the outputs. Every write carries a bit mask, so software can change one field and leave the other bits of the same register untouched.

Edits reach the live copy only through a commit. Software can hold a guard bit to collect a batch of edits. When it drops the guard and raises a commit request, the block copies the whole staging set into the live set in one clock, on the next frame-boundary strobe. A request made while the guard is held waits until the guard is dropped. Once the copy is done, the request bit clears by itself.

The control flow is handled by a small state machine with three states:
- `ST_IDLE`: no commit is waiting.
- `ST_HELD`: a commit is waiting but the guard is held.
- `ST_ARMED`: a commit is waiting and the guard is clear.

Its transitions are:
- IDLE→HELD: a request is written while the guard is, or becomes, set.
- IDLE→ARMED: a request is written while the guard is clear.
- HELD→ARMED: the guard is cleared.
- ARMED→HELD: the guard is set again.
- ARMED→IDLE: a frame strobe arrives and the copy is made.

Top module: `shadow_regbank`

## Requirements
- R1: After reset, every staging and live register is zero, the control register reads zero and all window enables are low.
- R2: A write to window register address a (addresses 1 to 10, where window w register r sits at 1+2w+r) stores (old & ~mask) | (data & mask) into the staging copy. A read of that address returns the staging copy as soon as the write edge has passed.
- R3: Writes to staging registers leave the live outputs unchanged until a commit transfers them.
- R4: Writing 1 to control bit 1 (address 0) with mask bit 1 set, while the guard is clear, makes bit 1 read 1. The next frame strobe copies all staging registers into the live set at that clock edge, and bit 1 then reads 0.
- R5: While the guard (control bit 0) is set, frame strobes cause no transfer, and a pending request stays visible in bit 1.
- R6: Clearing the guard while a request is pending lets the next frame strobe perform the transfer. Clearing the guard and raising the request in a single write also works.
- R7: Writing 0 to the request bit, or writing with its mask bit clear, does not cancel a pending request.
- R8: win_enable[w] is bit 0 of the live copy of window w register 0. Clearing every enable under the guard and then committing drops all enables at the same clock edge.
- R9: A frame strobe with no pending request changes nothing.
- R10: Writes to addresses 11 and above are ignored, and reads of those addresses return zero.
- R11: If the guard is set in the same cycle as a frame strobe while a commit is armed, the transfer is deferred and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address (0 = control register) |
| wr_data | input | DATA_W | Write data |
| wr_mask | input | DATA_W | Per-bit write mask; only bits set to 1 are changed |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data (staging copy or control register) |
| frame_tick | input | 1 | Frame-boundary strobe, one cycle wide |
| win_enable | output | NUM_WIN | Live enable bit of each window |
| win_active | output | NUM_REGS*DATA_W | Live copy of all window registers; slot a-1 holds address a |

## Verification
Read data is combinational from the staging copy, so it is sampled one nanosecond after the falling edge that follows a write. The control bits and staging values are due one rising edge after the write is driven. A live-set transfer is due at the rising edge where the strobe is seen in the armed state, so the live outputs are checked one nanosecond after that edge and again at the following falling edge. A behavioural model built only from a guard flag, a pending flag and two arrays steps at each rising edge and is compared with every output one nanosecond later. Directed checks with hand-computed values cover each corner, including the same-cycle guard-and-strobe case.

// File: rtl/srb_pkg.sv
package srb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HELD  = 2'd1,
        ST_ARMED = 2'd2
    } srb_state_e;

    // Control register bit positions (address 0)
    localparam int CTL_PROT_BIT = 0;
    localparam int CTL_REQ_BIT  = 1;
endpackage

// File: rtl/srb_ctrl_fsm.sv
module srb_ctrl_fsm
    import srb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_data,
    input  logic [1:0] ctl_mask,
    input  logic       frame_tick,
    output srb_state_e state_q,
    output logic       prot_q,
    output logic       pending,
    output logic       commit
);
    srb_state_e state_d;
    logic       nxt_prot;
    logic       req_set;

    // guard value after this cycle's write, and request strobe
    always_comb begin
        nxt_prot = prot_q;
        if (ctl_wr && ctl_mask[CTL_PROT_BIT])
            nxt_prot = ctl_data[CTL_PROT_BIT];
        req_set = ctl_wr && ctl_mask[CTL_REQ_BIT] && ctl_data[CTL_REQ_BIT];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_set) state_d = nxt_prot ? ST_HELD : ST_ARMED;
            ST_HELD:  if (!nxt_prot) state_d = ST_ARMED;
            ST_ARMED: begin
                if (nxt_prot)        state_d = ST_HELD;
                else if (frame_tick) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prot_q  <= nxt_prot;
        end
    end

    // outputs
    always_comb begin
        pending = (state_q != ST_IDLE);
        commit  = (state_q == ST_ARMED) && frame_tick && !nxt_prot;
    end
endmodule

// File: rtl/srb_window.sv
module srb_window #(
    parameter int REGS = 2,
    parameter int DW   = 32,
    parameter int AW   = 4,
    parameter int BASE = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW-1:0]      wr_mask,
    input  logic               commit,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [REGS*DW-1:0] act_flat,
    output logic               win_on
);
    logic [REGS-1:0][DW-1:0] shadow_q;
    logic [REGS-1:0][DW-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            for (int r = 0; r < REGS; r++) begin
                if (commit)
                    active_q[r] <= shadow_q[r];
                if (wr_en && (wr_addr == AW'(BASE + r)))
                    shadow_q[r] <= (shadow_q[r] & ~wr_mask) | (wr_data & wr_mask);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < REGS; r++)
            if (rd_addr == AW'(BASE + r))
                rd_data = rd_data | shadow_q[r];
    end

    genvar g;
    for (g = 0; g < REGS; g++) begin : g_flat
        assign act_flat[g*DW +: DW] = active_q[g];
    end

    assign win_on = active_q[0][0];
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
    import srb_pkg::*;
#(
    parameter int NUM_WIN      = 5,
    parameter int REGS_PER_WIN = 2,
    parameter int DATA_W       = 32,
    localparam int NUM_REGS    = NUM_WIN * REGS_PER_WIN,
    localparam int ADDR_W      = $clog2(NUM_REGS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [DATA_W-1:0]          wr_mask,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       frame_tick,
    output logic [NUM_WIN-1:0]         win_enable,
    output logic [NUM_REGS*DATA_W-1:0] win_active
);
    localparam int WIN_BITS = REGS_PER_WIN * DATA_W;

    srb_state_e ctl_state;
    logic       ctl_prot;
    logic       ctl_pend;
    logic       commit;
    logic       ctl_wr;
    logic [NUM_WIN-1:0][DATA_W-1:0] win_rd;

    assign ctl_wr = wr_en && (wr_addr == '0);

    srb_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_data   (wr_data[1:0]),
        .ctl_mask   (wr_mask[1:0]),
        .frame_tick (frame_tick),
        .state_q    (ctl_state),
        .prot_q     (ctl_prot),
        .pending    (ctl_pend),
        .commit     (commit)
    );

    genvar w;
    for (w = 0; w < NUM_WIN; w++) begin : g_win
        srb_window #(
            .REGS (REGS_PER_WIN),
            .DW   (DATA_W),
            .AW   (ADDR_W),
            .BASE (1 + w * REGS_PER_WIN)
        ) u_win (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .wr_mask  (wr_mask),
            .commit   (commit),
            .rd_addr  (rd_addr),
            .rd_data  (win_rd[w]),
            .act_flat (win_active[w*WIN_BITS +: WIN_BITS]),
            .win_on   (win_enable[w])
        );
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) begin
            rd_data[CTL_PROT_BIT] = ctl_prot;
            rd_data[CTL_REQ_BIT]  = ctl_pend;
        end else begin
            for (int i = 0; i < NUM_WIN; i++)
                rd_data = rd_data | win_rd[i];
        end
    end
endmodule

// File: rtl/shadow_regbank_chk.sv
module shadow_regbank_chk
    import srb_pkg::*;
#(
    parameter int W = 320
) (
    input logic         clk,
    input logic         rst_n,
    input logic         frame_tick,
    input logic [W-1:0] win_active,
    input srb_state_e   st,
    input logic         prot
);
    // R3 / R9: live set only moves on a frame strobe edge
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(win_active));

    // R5: guard held means no transfer at this edge
    a_r5_no_xfer_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        prot |=> $stable(win_active));

    // R4: after a transfer the request is no longer pending
    a_r4_clear_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_active) |-> (st == ST_IDLE));

    // R5: a held request never silently vanishes
    a_r5_held_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HELD) |=> (st != ST_IDLE));

    // R7: without a strobe a pending request cannot be dropped
    a_r7_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && !frame_tick) |=> (st != ST_IDLE));
endmodule

bind shadow_regbank shadow_regbank_chk #(.W(NUM_REGS * DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .win_active (win_active),
    .st         (ctl_state),
    .prot       (ctl_prot)
);

// File: tb/shadow_regbank_tb.sv
`timescale 1ns/1ps
module shadow_regbank_tb;
    localparam int NW = 5, RPW = 2, DW = 32, NR = NW * RPW, AW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, wr_mask = '0;
    logic frame_tick = 1'b0;
    logic [DW-1:0] rd_data;
    logic [NW-1:0] win_enable;
    logic [NR*DW-1:0] win_active;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    shadow_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .frame_tick(frame_tick),
        .win_enable(win_enable), .win_active(win_active)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_sh [NR];
    logic [DW-1:0] m_act [NR];
    bit m_prot, m_pend;

    always @(posedge clk) begin
        bit nprot, rset, xfer;
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_sh[i] = '0; m_act[i] = '0; end
            m_prot = 0; m_pend = 0;
        end else begin
            nprot = (wr_en && wr_addr == 0 && wr_mask[0]) ? wr_data[0] : m_prot;
            rset  = wr_en && wr_addr == 0 && wr_mask[1] && wr_data[1];
            xfer  = m_pend && !m_prot && frame_tick && !nprot;
            if (xfer) for (int i = 0; i < NR; i++) m_act[i] = m_sh[i];
            if (wr_en && wr_addr >= 1 && wr_addr <= NR)
                m_sh[wr_addr-1] = (m_sh[wr_addr-1] & ~wr_mask) | (wr_data & wr_mask);
            m_pend = xfer ? 1'b0 : (m_pend || rset);
            m_prot = nprot;
        end
        #1;
        if (rst_n && !done) begin
            logic [DW-1:0] exp_rd;
            if (rd_addr == 0) exp_rd = {30'd0, m_pend, m_prot};
            else if (rd_addr <= NR) exp_rd = m_sh[rd_addr-1];
            else exp_rd = '0;
            chk("R2 model read", rd_data, exp_rd);
            for (int i = 0; i < NR; i++)
                chk("R4 model live slot", win_active[i*DW +: DW], m_act[i]);
            for (int w = 0; w < NW; w++)
                chk("R8 model enable", {31'd0, win_enable[w]}, {31'd0, m_act[w*RPW][0]});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
        @(negedge clk);
        wr_en = 1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [DW-1:0] exp);
        rd_addr = AW'(a); #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic en_chk(input string tag, input logic [NW-1:0] exp);
        #1; chk(tag, {27'd0, win_enable}, {27'd0, exp});
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd_chk("R1 ctrl after reset", 0, 32'h0);
        rd_chk("R1 reg after reset", 5, 32'h0);
        en_chk("R1 enables after reset", 5'b00000);

        wr(1, 32'h0000_00A5, 32'hFFFF_FFFF);
        rd_chk("R2 full write", 1, 32'h0000_00A5);
        wr(1, 32'hFFFF_FF00, 32'h0000_0F00);
        rd_chk("R2 masked write keeps other bits", 1, 32'h0000_0FA5);
        en_chk("R3 live unchanged by staging write", 5'b00000);
        chk("R3 live slot0", win_active[31:0], 32'h0);

        tick();
        en_chk("R9 tick without request", 5'b00000);

        wr(0, 32'h2, 32'h2);
        rd_chk("R4 request visible", 0, 32'h2);
        tick();
        en_chk("R4 enable after commit", 5'b00001);
        chk("R4 live slot0 after commit", win_active[31:0], 32'h0000_0FA5);
        rd_chk("R4 request self-clears", 0, 32'h0);

        wr(0, 32'h1, 32'h1);
        for (int w = 1; w < NW; w++) wr(1 + 2*w, 32'h1, 32'h1);
        wr(0, 32'h2, 32'h2);
        rd_chk("R5 guard and pending", 0, 32'h3);
        repeat (3) tick();
        en_chk("R5 no transfer while guarded", 5'b00001);
        wr(0, 32'h0, 32'h2);
        rd_chk("R7 zero write does not cancel", 0, 32'h3);
        wr(0, 32'h2, 32'h0);
        rd_chk("R7 masked-off write does not cancel", 0, 32'h3);
        wr(0, 32'h0, 32'h1);
        rd_chk("R6 guard released, still pending", 0, 32'h2);
        tick();
        en_chk("R6 transfer after release", 5'b11111);
        rd_chk("R6 request cleared", 0, 32'h0);

        wr(0, 32'h1, 32'h1);
        for (int w = 0; w < NW; w++) wr(1 + 2*w, 32'h0, 32'h1);
        tick();
        en_chk("R8 still lit under guard", 5'b11111);
        wr(0, 32'h2, 32'h3);
        rd_chk("R6 release and request in one write", 0, 32'h2);
        en_chk("R8 lit before boundary", 5'b11111);
        tick();
        en_chk("R8 all blank at one edge", 5'b00000);

        wr(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_chk("R10 out of range reads zero", 12, 32'h0);
        rd_chk("R10 in-range untouched", 1, 32'h0000_0FA4);

        wr(2, 32'h0000_1234, 32'hFFFF_FFFF);
        wr(0, 32'h2, 32'h2);
        @(negedge clk);
        wr_en = 1; wr_addr = 0; wr_data = 32'h1; wr_mask = 32'h1; frame_tick = 1;
        @(negedge clk);
        wr_en = 0; frame_tick = 0;
        #1; chk("R11 transfer deferred", win_active[63:32], 32'h0);
        rd_chk("R11 still pending under guard", 0, 32'h3);
        wr(0, 32'h0, 32'h1);
        tick();
        #1; chk("R11 transfer after release", win_active[63:32], 32'h0000_1234);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule